// File: doc/BRIEF.md
# Multi-Bank Glitch-Free Clock Divider

This block takes one fast source clock and derives thirteen slower clocks from it. There are three banks of four outputs and one feedback output. Each output is an even division of the source clock with a 50% duty cycle. Each bank has a two-bit ratio select. The feedback output has its own two-bit select. A shared prescale control halves every ratio when it is high.

Selects can change while the clocks run. Each divider keeps the new setting in a shadow register. It applies that setting only at the instant its output is about to rise, so a phase that is already running always completes at its old length. Eleven of the outputs can be frozen low through a run mask, and a freeze only takes hold during a low phase. The last two outputs of bank C can be inverted. The active-low master reset clears every flop and forces all outputs low. On release, every output that is allowed to run rises on the same clock edge.

Top module: `mbd_clock_divider`

## Requirements
- R1: Bank A (`qa`) divides the source by 8, 12, 16, 24 for `sel_a` = 0, 1, 2, 3 when `prescale_off` is 0, and by 4, 6, 8, 12 when `prescale_off` is 1.
- R2: Bank B (`qb`) divides by 8, 12, 16, 20 for `sel_b` = 0..3 with `prescale_off` = 0, and by 4, 6, 8, 10 with `prescale_off` = 1.
- R3: Bank C (`qc`) divides by 4, 8, 12, 16 for `sel_c` = 0..3 with `prescale_off` = 0, and by 2, 4, 6, 8 with `prescale_off` = 1.
- R4: `fb_out` uses the bank B ratio set, selected by `sel_fb` and `prescale_off`.
- R5: A change of a select or of `prescale_off` takes effect at the first rising edge of the output after the change. The high phase and low phase that are running when the change arrives complete at the old length, so every phase has either the old or the new length.
- R6: Every output is high for exactly half its divide count and low for exactly half. The low phase always has the same length as the high phase that precedes it.
- R7: While `rst_n` is 0 at a clock edge, all outputs are 0 after that edge. On the first edge with `rst_n` = 1, every output that is not frozen and not inverted rises.
- R8: When `inv_c` is 1, `qc[2]` and `qc[3]` carry the inverse of the bank C clock. When `inv_c` is 0, they equal `qc[1]`.
- R9: A 0 in `run_mask` holds the matching output at 0. The bit layout is: bits 3:0 for `qa[3:0]`, bits 7:4 for `qb[3:0]`, and bits 10:8 for `qc[3:1]`.
- R10: A `run_mask` change applies only while the output's own phase is low. A pulse already begun completes at full length, and an output that is unfrozen starts with a full-length high phase.
- R11: `qc[0]` and `fb_out` cannot be frozen; they run whatever `run_mask` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low master reset; low also disables all outputs |
| prescale_off | input | 1 | 1 bypasses the shared /2 prescale (smaller ratios) |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 2 | Feedback ratio select |
| inv_c | input | 1 | Inverts qc[2] and qc[3] when 1 |
| run_mask | input | 11 | Per-output run enable, 0 freezes low |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks |
| fb_out | output | 1 | Feedback clock |

## Verification
The bench builds the block with its defaults: four outputs per bank and a 5-bit phase counter. These cover every ratio from 2 up to 24, and the full 11-bit run mask.

Every ratio code of every bank is measured under both prescale settings. Ratio changes are made in the middle of a high phase, in both directions and through the prescale control, so that the completed old phases and the first new phases can be counted. Freeze and unfreeze are issued during high phases to test for partial pulses.

// File: rtl/mbd_pkg.sv
// Shared types and ratio lookup for the multi-bank divider.
// Assumes all ratios are even; the lookup returns half the divide count.
package mbd_pkg;

    typedef enum logic [1:0] {
        BANK_A  = 2'd0,
        BANK_B  = 2'd1,
        BANK_C  = 2'd2,
        BANK_FB = 2'd3
    } bank_e;

    // Half of the divide count for a bank, select code and prescale state.
    function automatic int unsigned half_count(bank_e bank, logic [1:0] sel, logic prescale_off);
        int unsigned base;
        unique case (bank)
            BANK_A: begin
                unique case (sel)
                    2'd0: base = 2;
                    2'd1: base = 3;
                    2'd2: base = 4;
                    default: base = 6;
                endcase
            end
            BANK_C: base = int'(sel) + 1;
            default: base = int'(sel) + 2;
        endcase
        return prescale_off ? base : (base << 1);
    endfunction

endpackage

// File: rtl/mbd_divider.sv
// Even divider with 50% duty for one bank.
// A new ratio is held in a shadow register and loaded only at the point
// where the output rises, so each low phase matches the high phase before it.
// Assumes CNT_W is wide enough for the largest half count.
module mbd_divider #(
    parameter mbd_pkg::bank_e BANK  = mbd_pkg::BANK_A,
    parameter int             CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       prescale_off,
    output logic       level
);
    localparam int RUN_W = CNT_W + 2;

    logic [1:0]       sel_sh;
    logic             pre_sh;
    logic [CNT_W-1:0] half_new;
    logic [CNT_W-1:0] half_cur;
    logic [CNT_W-1:0] cnt;

    // Shadow copy of the select inputs, taken every cycle.
    always_ff @(posedge clk) begin
        sel_sh <= sel;
        pre_sh <= prescale_off;
    end

    assign half_new = CNT_W'(mbd_pkg::half_count(BANK, sel_sh, pre_sh));

    // Phase counter: toggle at zero and load the new ratio only on a rising toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            level    <= 1'b0;
            half_cur <= half_new;
        end else if (cnt == '0) begin
            level <= ~level;
            if (!level) begin
                half_cur <= half_new;
                cnt      <= half_new - 1'b1;
            end else begin
                cnt <= half_cur - 1'b1;
            end
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Phase-length tracking used only by the checks below.
    logic             lvl_d;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d   <= 1'b0;
            run_len <= '0;
            hi_len  <= '0;
        end else begin
            lvl_d <= level;
            if (level != lvl_d) begin
                run_len <= RUN_W'(1);
                if (lvl_d) hi_len <= run_len;
            end else if (run_len != '1) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    // R6: a completed low phase is as long as the high phase before it.
    a_r6_equal_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (level && !lvl_d && hi_len != '0) |-> (run_len == hi_len));

    // R5: the active ratio changes only together with a rising output.
    a_r5_load_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half_cur) |-> $rose(level));

endmodule

// File: rtl/mbd_gate.sv
// Freeze gate for one output. The run enable is sampled only while the
// phase (after any inversion) is low, so no pulse is ever cut or shortened.
// Assumes phase is a registered, glitch-free clock level.
module mbd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic phase,
    input  logic run,
    output logic out
);
    logic en_q;

    // Capture the run enable only during a low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (!phase) en_q <= run;
    end

    assign out = phase & en_q;

    // R10: the gated output rises only together with its phase.
    a_r10_rise_with_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out) |-> $rose(phase));

    // R10: the gated output falls only together with its phase.
    a_r10_fall_with_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out) |-> $fell(phase));

endmodule

// File: rtl/mbd_clock_divider.sv
// Top of the multi-bank divider: three banks plus a feedback output, each
// an even divider of clk, with shared prescale, inversion of the last two
// bank C outputs, and per-output freeze gating.
// Assumes clk is the fast source clock and rst_n is synchronous to it.
module mbd_clock_divider #(
    parameter int NUM_OUT = 4,
    parameter int CNT_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prescale_off,
    input  logic [1:0]             sel_a,
    input  logic [1:0]             sel_b,
    input  logic [1:0]             sel_c,
    input  logic [1:0]             sel_fb,
    input  logic                   inv_c,
    input  logic [3*NUM_OUT-2:0]   run_mask,
    output logic [NUM_OUT-1:0]     qa,
    output logic [NUM_OUT-1:0]     qb,
    output logic [NUM_OUT-1:0]     qc,
    output logic                   fb_out
);
    localparam int MASK_B = NUM_OUT;
    localparam int MASK_C = 2 * NUM_OUT - 1;
    localparam int INV_LO = NUM_OUT - 2;

    logic lvl_a, lvl_b, lvl_c, lvl_fb;

    mbd_divider #(.BANK(mbd_pkg::BANK_A), .CNT_W(CNT_W)) div_a_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_a), .prescale_off(prescale_off), .level(lvl_a));
    mbd_divider #(.BANK(mbd_pkg::BANK_B), .CNT_W(CNT_W)) div_b_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_b), .prescale_off(prescale_off), .level(lvl_b));
    mbd_divider #(.BANK(mbd_pkg::BANK_C), .CNT_W(CNT_W)) div_c_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_c), .prescale_off(prescale_off), .level(lvl_c));
    mbd_divider #(.BANK(mbd_pkg::BANK_FB), .CNT_W(CNT_W)) div_fb_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_fb), .prescale_off(prescale_off), .level(lvl_fb));

    // R11: the first bank C output and the feedback output bypass the gates.
    assign qc[0]  = lvl_c;
    assign fb_out = lvl_fb;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ab
        mbd_gate gate_a_i (.clk(clk), .rst_n(rst_n), .phase(lvl_a),
                           .run(run_mask[i]), .out(qa[i]));
        mbd_gate gate_b_i (.clk(clk), .rst_n(rst_n), .phase(lvl_b),
                           .run(run_mask[MASK_B + i]), .out(qb[i]));
    end

    for (genvar i = 1; i < NUM_OUT; i++) begin : g_c
        logic phase_c;
        if (i >= INV_LO) begin : g_inv
            assign phase_c = lvl_c ^ inv_c;
        end else begin : g_plain
            assign phase_c = lvl_c;
        end
        mbd_gate gate_c_i (.clk(clk), .rst_n(rst_n), .phase(phase_c),
                           .run(run_mask[MASK_C + i]), .out(qc[i]));
    end

    // Remembers that the last edge saw reset, for the quiet-output check.
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R7: after an edge with reset low, every output is low.
    always @(negedge clk) begin
        if (rst_seen_q) begin
            a_r7_reset_quiet: assert (qa == '0 && qb == '0 && qc == '0 && !fb_out);
        end
    end

endmodule

// File: tb/mbd_clock_divider_tb.sv
// Directed bench for mbd_clock_divider. Samples outputs at falling edges.
module mbd_clock_divider_tb_top;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prescale_off = 1'b0;
    logic [1:0]    sel_a = '0, sel_b = '0, sel_c = '0, sel_fb = '0;
    logic          inv_c = 1'b0;
    logic [10:0]   run_mask = '1;
    logic [N-1:0]  qa, qb, qc;
    logic          fb_out;
    logic [12:0]   all_q;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mbd_clock_divider dut_i (
        .clk(clk), .rst_n(rst_n), .prescale_off(prescale_off),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c(inv_c), .run_mask(run_mask),
        .qa(qa), .qb(qb), .qc(qc), .fb_out(fb_out));

    // Index map: qa0=0, qb0=4, qc0=8, qc1=9, qc2=10, qc3=11, fb=12.
    assign all_q = {fb_out, qc, qb, qa};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_half(input int bank, input int s, input bit off);
        int base;
        case (bank)
            0: base = (s == 3) ? 6 : s + 2;
            2: base = s + 1;
            default: base = s + 2;
        endcase
        return off ? base : 2 * base;
    endfunction

    // Waits until output idx is seen rising; ends at its first high sample.
    task automatic wait_rise(input int idx);
        logic p;
        p = all_q[idx];
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (!p && all_q[idx]) return;
            p = all_q[idx];
        end
    endtask

    // Counts samples for which output idx keeps its present value.
    task automatic phase_len(input int idx, output int len);
        logic v;
        v = all_q[idx];
        len = 1;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (all_q[idx] != v) return;
            len++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(all_q == '0, "R7 outputs low in reset", int'(all_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(all_q == 13'h1fff, "R7 common first rise", int'(all_q), 13'h1fff);
    endtask

    task automatic t_ratios();
        int idxs[4] = '{0, 4, 8, 12};
        int banks[4] = '{0, 1, 2, 3};
        string names[4] = '{"R1 bank A", "R2 bank B", "R3 bank C", "R4 feedback"};
        int hi, lo, h;
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 4; s++) begin
                prescale_off = p[0];
                sel_a = s[1:0]; sel_b = s[1:0]; sel_c = s[1:0]; sel_fb = s[1:0];
                repeat (60) @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    h = exp_half(banks[k], s, p[0]);
                    wait_rise(idxs[k]);
                    phase_len(idxs[k], hi);
                    phase_len(idxs[k], lo);
                    check(hi == h, names[k], hi, h);
                    check(lo == h, "R6 low phase", lo, h);
                end
            end
        end
    endtask

    task automatic t_on_fly();
        int len;
        prescale_off = 1'b0; sel_a = 2'd0;
        repeat (60) @(negedge clk);
        wait_rise(0);
        sel_a = 2'd3;                       // change inside a 4-cycle high phase
        phase_len(0, len); check(len == 4,  "R5 old high completes", len, 4);
        phase_len(0, len); check(len == 4,  "R5 old low completes", len, 4);
        phase_len(0, len); check(len == 12, "R5 new high", len, 12);
        phase_len(0, len); check(len == 12, "R5 new low", len, 12);
        sel_a = 2'd0;                       // now at first sample of a 12-cycle high
        phase_len(0, len); check(len == 12, "R5 long high completes", len, 12);
        phase_len(0, len); check(len == 12, "R5 long low completes", len, 12);
        phase_len(0, len); check(len == 4,  "R5 short high", len, 4);
        sel_a = 2'd3;
        wait_rise(0);
        prescale_off = 1'b1;                // at first sample of a 12-cycle high
        phase_len(0, len); check(len == 12, "R5 prescale old high", len, 12);
        phase_len(0, len); check(len == 12, "R5 prescale old low", len, 12);
        phase_len(0, len); check(len == 6,  "R5 prescale new high", len, 6);
        phase_len(0, len); check(len == 6,  "R5 prescale new low", len, 6);
    endtask

    task automatic t_invert();
        int bad;
        prescale_off = 1'b0; sel_c = 2'd1; run_mask = '1;
        inv_c = 1'b1;
        repeat (40) @(negedge clk);
        bad = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (qc[2] == qc[1] || qc[3] != qc[2]) bad++;
        end
        check(bad == 0, "R8 inverted pair", bad, 0);
        inv_c = 1'b0;
        repeat (40) @(negedge clk);
        bad = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (qc[2] != qc[1] || qc[3] != qc[1]) bad++;
        end
        check(bad == 0, "R8 plain pair", bad, 0);
    endtask

    task automatic t_freeze();
        int leak, r_c0, r_fb, r_a1;
        logic [12:0] prev;
        prescale_off = 1'b1; sel_a = 2'd0; sel_c = 2'd0; sel_fb = 2'd0;
        run_mask = '0;
        repeat (30) @(negedge clk);
        leak = 0; r_c0 = 0; r_fb = 0;
        prev = all_q;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if ((all_q & 13'h0eff) != '0) leak++;
            if (!prev[8] && all_q[8]) r_c0++;
            if (!prev[12] && all_q[12]) r_fb++;
            prev = all_q;
        end
        check(leak == 0, "R9 all masked outputs low", leak, 0);
        check(r_c0 > 0, "R11 qc0 runs", r_c0, 1);
        check(r_fb > 0, "R11 fb_out runs", r_fb, 1);
        run_mask = 11'h7fe;
        repeat (30) @(negedge clk);
        leak = 0; r_a1 = 0;
        prev = all_q;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (qa[0]) leak++;
            if (!prev[1] && all_q[1]) r_a1++;
            prev = all_q;
        end
        check(leak == 0, "R9 qa0 frozen", leak, 0);
        check(r_a1 > 0, "R9 qa1 still runs", r_a1, 1);
    endtask

    task automatic t_no_partial();
        int len, leak;
        prescale_off = 1'b0; sel_a = 2'd0;     // half count 4
        run_mask = 11'h7fe;
        repeat (40) @(negedge clk);
        wait_rise(1);
        run_mask = '1;                         // unfreeze during a high phase
        check(qa[0] == 1'b0, "R10 no mid-phase start", int'(qa[0]), 0);
        wait_rise(0);
        check(qa[1] == 1'b1, "R10 starts with sibling rise", int'(qa[1]), 1);
        phase_len(0, len);
        check(len == 4, "R10 first pulse full", len, 4);
        wait_rise(0);
        run_mask = 11'h7fe;                    // freeze during a high phase
        phase_len(0, len);
        check(len == 4, "R10 last pulse full", len, 4);
        leak = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (qa[0]) leak++;
        end
        check(leak == 0, "R10 stays frozen", leak, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ratios();
        t_on_fly();
        t_invert();
        t_freeze();
        t_no_partial();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule